// File: doc/BRIEF.md
# SSP-to-I2S Frame Format Bridge

This block joins a synchronous serial port, which marks the start of every word with a single-clock frame pulse, to an external I2S codec, which expects a level-type word-select that changes once per channel. The bridge works as the I2S master. It forwards the bit clock to the codec and builds word-select by flipping its level on every frame pulse. A static control input can hold that change back by one bit clock. Transmit data from the serial port is retimed onto the codec data line.

On the receive side the bridge samples the codec's data on the rising bit-clock edge and passes it through a one-word delay pipe. Each word therefore reaches the serial port in the frame after the one in which the codec sent it. The lag is the same for both word-select settings. The receive line toward the serial port is held low while the pipe fills, so the serial port reads zeros for its first two words after reset.

All outputs toward both sides change on the falling bit-clock edge. All inputs are sampled on the rising edge. Words are WORD_W bits long (16 by default) and are sent MSB first with no gap between words. The frame pulse is high for the one clock before each MSB.

Top module: `ssp_i2s_bridge`

## Requirements
- R1: While rst_n is low (synchronous, sampled on the rising edge), i2s_ws_o, i2s_txd_o and ssp_rxd_o are 0 from the next falling edge on, whatever the data and frame inputs do.
- R2: i2s_ws_o changes level once for each frame pulse and at no other time. After reset it starts low, so the first pulse drives it high.
- R3: If ssp_frm_i is sampled high at rising edge t, the new word-select level is present at rising edge t+1 when wsdel_i=0, and at rising edge t+2 when wsdel_i=1.
- R4: The ssp_txd_i value sampled at rising edge c appears on i2s_txd_o at rising edge c+1. Bit order is kept, so a word that arrives MSB first with no gaps leaves MSB first with no gaps.
- R5: The codec sends the word for frame k MSB first, starting one clock after it sees the word-select change. That word appears on ssp_rxd_o MSB first during frame k+1: for a frame pulse at t, bit i is present at rising edge t+1+i.
- R6: The one-frame receive lag of R5 holds for both wsdel_i=0 and wsdel_i=1.
- R7: ssp_rxd_o stays 0 until the third frame pulse after reset. The serial port therefore reads zero for frames 0 and 1, even if the codec line carries ones before the first frame or during frame 0.
- R8: i2s_ws_o, i2s_txd_o and ssp_rxd_o change only on falling edges. Their values at a rising edge equal their values just after it.
- R9: i2s_sck_o is the bit clock itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wsdel_i | input | 1 | 1 = hold the word-select change back by one bit clock; static while running |
| ssp_frm_i | input | 1 | Frame pulse from the serial port, high the clock before each MSB |
| ssp_txd_i | input | 1 | Transmit data from the serial port |
| ssp_rxd_o | output | 1 | Delayed codec data toward the serial port |
| i2s_sck_o | output | 1 | Bit clock toward the codec |
| i2s_ws_o | output | 1 | Word-select toward the codec, low = left |
| i2s_txd_o | output | 1 | Transmit data toward the codec |
| i2s_rxd_i | input | 1 | Receive data from the codec |

## Verification
The hardest case to reach from the ports is the fill gate. It only shows up if the codec line carries non-zero data before the delay pipe has seen a full frame. A bridge that merely resets its pipe to zero would still leak the codec's frame-0 word into frame 1. To expose that, the stimulus drives ones on the codec line through reset and up to the first frame, and it gives the codec a non-zero first word. This is run with both word-select delays, so the tap that changes with wsdel_i is also caught if it is off by one.

// File: rtl/i2sconv_pkg.sv
// Shared types for the SSP-to-I2S bridge.
package i2sconv_pkg;

    // Progress of the receive delay pipe toward carrying live codec data.
    typedef enum logic [1:0] {
        FILL_EMPTY  = 2'd0,
        FILL_FIRST  = 2'd1,
        FILL_SECOND = 2'd2,
        FILL_LIVE   = 2'd3
    } fill_state_e;

endpackage

// File: rtl/i2sconv_ws_gen.sv
// Word-select generator.
// Flips a level on every frame pulse sampled at the rising edge. The result
// can be held back by one extra bit clock. The output is still in the
// rising-edge domain; the caller retimes it onto the falling edge.
// Assumes wsdel_i is static while frames are running.
module i2sconv_ws_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_i,
    input  logic wsdel_i,
    output logic ws_o
);

    logic ws_lvl;
    logic ws_lag;
    logic armed;

    // Flip the channel level on each frame pulse; left (low) after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) ws_lvl <= 1'b0;
        else if (frame_i) ws_lvl <= ~ws_lvl;
    end

    // One-clock alignment stage used when the delayed setting is chosen.
    always_ff @(posedge clk) begin
        if (!rst_n) ws_lag <= 1'b0;
        else ws_lag <= ws_lvl;
    end

    // Marks that at least one cycle has passed since reset, for the checks.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else armed <= 1'b1;
    end

    // Pick the direct or the delayed level.
    always_comb begin
        ws_o = wsdel_i ? ws_lag : ws_lvl;
    end

    // R2: a frame pulse flips the level.
    p_ws_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(frame_i)) |-> (ws_lvl != $past(ws_lvl)));

    // R2: without a frame pulse the level holds.
    p_ws_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !$past(frame_i)) |-> $stable(ws_lvl));

    // R3: in the delayed setting the output trails the level by one clock.
    p_wsdel_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && wsdel_i && $past(wsdel_i)) |-> (ws_o == $past(ws_lvl)));

endmodule

// File: rtl/i2sconv_rx_pipe.sv
// Receive delay pipe.
// Samples codec data on the rising edge into a shift register WORD_W-1 deep.
// The output tap moves by one stage with the word-select delay setting, so
// every codec word comes out in the next serial-port frame. The output is
// forced low until the third frame pulse after reset.
// Assumes WORD_W >= 4 and that wsdel_i is static while running.
module i2sconv_rx_pipe
    import i2sconv_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_i,
    input  logic wsdel_i,
    input  logic rxd_i,
    output logic bit_o
);

    localparam int DEPTH    = WORD_W - 1;
    localparam int TAP_NEAR = DEPTH - 1;
    localparam int TAP_FAR  = DEPTH - 2;

    logic [DEPTH-1:0] shreg;
    fill_state_e      fill;
    logic             armed;
    logic             tapped;

    // Shift codec samples in on each rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) shreg <= '0;
        else shreg <= {shreg[DEPTH-2:0], rxd_i};
    end

    // Count frame pulses up to the live state.
    always_ff @(posedge clk) begin
        if (!rst_n) fill <= FILL_EMPTY;
        else if (frame_i && fill != FILL_LIVE) fill <= fill_state_e'(fill + 2'd1);
    end

    // Marks that at least one cycle has passed since reset, for the checks.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else armed <= 1'b1;
    end

    // Pick the tap that matches the codec's word start for this setting.
    always_comb begin
        tapped = wsdel_i ? shreg[TAP_FAR] : shreg[TAP_NEAR];
    end

    // Hold the serial-port line low until the pipe carries live data.
    always_comb begin
        bit_o = (fill == FILL_LIVE) ? tapped : 1'b0;
    end

    // R7: nothing reaches the serial port before the live state.
    p_quiet_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fill != FILL_LIVE) |-> (bit_o == 1'b0));

    // R7: the fill state moves only on frame pulses.
    p_fill_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !$past(frame_i)) |-> $stable(fill));

    // R7: the live state is never left without a reset.
    p_fill_live_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(fill) == FILL_LIVE) |-> (fill == FILL_LIVE));

endmodule

// File: rtl/i2sconv_neg_retime.sv
// Falling-edge retiming bank.
// Moves WIDTH signals from the rising-edge domain onto falling-edge flops,
// so the outputs change only in the middle of each bit period.
// Reset is synchronous and sampled on the falling edge.
module i2sconv_neg_retime #(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        // Launch one output bit on the falling edge.
        always_ff @(negedge clk) begin
            if (!rst_n) q_o[g] <= 1'b0;
            else q_o[g] <= d_i[g];
        end
    end

endmodule

// File: rtl/ssp_i2s_bridge.sv
// SSP-to-I2S frame format bridge (master side).
// Forwards the bit clock to the codec, turns the serial port's frame pulses
// into a level word-select, retimes transmit data, and hands codec data back
// to the serial port one frame late through the receive delay pipe.
// Assumes the frame pulse is one clock wide, one clock before each MSB, and
// that wsdel_i changes only while in reset.
module ssp_i2s_bridge #(
    parameter int WORD_W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wsdel_i,
    input  logic ssp_frm_i,
    input  logic ssp_txd_i,
    output logic ssp_rxd_o,
    output logic i2s_sck_o,
    output logic i2s_ws_o,
    output logic i2s_txd_o,
    input  logic i2s_rxd_i
);

    localparam int OUT_N  = 3;
    localparam int IDX_WS = 0;
    localparam int IDX_TX = 1;
    localparam int IDX_RX = 2;

    logic             ws_pos;
    logic             tx_pos;
    logic             rx_pos;
    logic [OUT_N-1:0] out_pos;
    logic [OUT_N-1:0] out_neg;

    // Capture transmit data from the serial port on the rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) tx_pos <= 1'b0;
        else tx_pos <= ssp_txd_i;
    end

    i2sconv_ws_gen u_ws (
        .clk     (clk),
        .rst_n   (rst_n),
        .frame_i (ssp_frm_i),
        .wsdel_i (wsdel_i),
        .ws_o    (ws_pos)
    );

    i2sconv_rx_pipe #(.WORD_W(WORD_W)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .frame_i (ssp_frm_i),
        .wsdel_i (wsdel_i),
        .rxd_i   (i2s_rxd_i),
        .bit_o   (rx_pos)
    );

    // Gather the rising-edge results for the falling-edge bank.
    always_comb begin
        out_pos         = '0;
        out_pos[IDX_WS] = ws_pos;
        out_pos[IDX_TX] = tx_pos;
        out_pos[IDX_RX] = rx_pos;
    end

    i2sconv_neg_retime #(.WIDTH(OUT_N)) u_retime (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (out_pos),
        .q_o   (out_neg)
    );

    // Drive the pins from the falling-edge bank and forward the clock.
    always_comb begin
        i2s_ws_o  = out_neg[IDX_WS];
        i2s_txd_o = out_neg[IDX_TX];
        ssp_rxd_o = out_neg[IDX_RX];
        i2s_sck_o = clk;
    end

endmodule

// File: tb/ssp_i2s_bridge_bench.sv
module ssp_i2s_bridge_bench;

    localparam int W  = 16;
    localparam int T0 = 4;

    logic clk   = 1'b0;
    logic rst_n = 1'b0;
    logic wsdel = 1'b0;
    logic frm   = 1'b0;
    logic stxd  = 1'b0;
    logic crxd  = 1'b0;
    logic srxd, sck, ws, itxd;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    ssp_i2s_bridge #(.WORD_W(W)) u_ssp_i2s_bridge (
        .clk       (clk),
        .rst_n     (rst_n),
        .wsdel_i   (wsdel),
        .ssp_frm_i (frm),
        .ssp_txd_i (stxd),
        .ssp_rxd_o (srxd),
        .i2s_sck_o (sck),
        .i2s_ws_o  (ws),
        .i2s_txd_o (itxd),
        .i2s_rxd_i (crxd)
    );

    task automatic check(input string req, input logic act, input logic exp, input int c);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s cycle %0d actual=%b expected=%b", req, c, act, exp);
        end
    endtask

    function automatic logic [W-1:0] tx_word(input int k);
        logic [31:0] v;
        v = 32'h0000B4E1 + k * 32'h00003B17;
        return v[W-1:0];
    endfunction

    function automatic logic [W-1:0] codec_word(input int k);
        logic [31:0] v;
        v = 32'h00008E25 + k * 32'h00001D4B;
        return v[W-1:0];
    endfunction

    // Hold reset with busy inputs and check the quiet outputs (R1).
    task automatic do_reset(input logic d, input logic junk);
        @(negedge clk);
        #1;
        rst_n = 1'b0;
        wsdel = d;
        frm   = 1'b1;
        stxd  = 1'b1;
        crxd  = junk;
        repeat (3) @(negedge clk);
        #1;
        check("R1 ws in reset", ws, 1'b0, -1);
        check("R1 txd in reset", itxd, 1'b0, -1);
        check("R1 rxd in reset", srxd, 1'b0, -1);
    endtask

    // Run nfr frames and check every output in every cycle (R2-R9).
    task automatic run_stream(input logic d, input int nfr, input logic junk);
        logic [W-1:0] wv;
        logic exp_ws, exp_tx, exp_rx, prev_tx;
        logic s_ws, s_tx, s_rx;
        int   f, i, off, cnt;
        do_reset(d, junk);
        prev_tx = 1'b0;
        for (int c = 0; c < T0 + nfr * W + 6; c++) begin
            if (c > 0) begin
                @(negedge clk);
                #1;
            end
            rst_n = 1'b1;
            // Serial-port side stimulus.
            frm = (c >= T0) && ((c - T0) % W == 0) && ((c - T0) / W < nfr);
            stxd = 1'b0;
            if (c > T0) begin
                f = (c - T0 - 1) / W;
                i = (c - T0 - 1) % W;
                if (f < nfr) begin
                    wv = tx_word(f);
                    stxd = wv[W-1-i];
                end
            end
            // Codec model: MSB one clock after it sees the word-select change.
            off = c - T0 - 2 - int'(d);
            if (off >= 0) begin
                f = off / W;
                i = off % W;
                crxd = 1'b0;
                if (f < nfr) begin
                    wv = codec_word(f);
                    crxd = wv[W-1-i];
                end
            end else begin
                crxd = junk;
            end
            // Expected values at rising edge c.
            cnt = 0;
            for (int k = 0; k < nfr; k++)
                if (T0 + k * W + 1 + int'(d) <= c) cnt++;
            exp_ws = cnt[0];
            exp_tx = prev_tx;
            exp_rx = 1'b0;
            if (c > T0) begin
                f = (c - T0 - 1) / W;
                i = (c - T0 - 1) % W;
                if (f >= 2 && f - 1 < nfr) begin
                    wv = codec_word(f - 1);
                    exp_rx = wv[W-1-i];
                end
            end
            #7;
            s_ws = ws;
            s_tx = itxd;
            s_rx = srxd;
            check(d ? "R2/R3 ws (wsdel=1)" : "R2/R3 ws (wsdel=0)", s_ws, exp_ws, c);
            check("R4 txd", s_tx, exp_tx, c);
            check(d ? "R5/R6/R7 rxd (wsdel=1)" : "R5/R6/R7 rxd (wsdel=0)", s_rx, exp_rx, c);
            check("R9 sck low", sck, 1'b0, c);
            prev_tx = stxd;
            @(posedge clk);
            #2;
            check("R8 ws stable over rise", ws, s_ws, c);
            check("R8 txd stable over rise", itxd, s_tx, c);
            check("R8 rxd stable over rise", srxd, s_rx, c);
            check("R9 sck high", sck, 1'b1, c);
        end
    endtask

    task automatic scn_plain_wsdel0();
        run_stream(1'b0, 6, 1'b0);
    endtask

    task automatic scn_junk_wsdel1();
        run_stream(1'b1, 6, 1'b1);
    endtask

    task automatic scn_junk_wsdel0_short();
        run_stream(1'b0, 4, 1'b1);
    endtask

    initial begin
        scn_plain_wsdel0();
        scn_junk_wsdel1();
        scn_junk_wsdel0_short();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(20 * 200000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule